// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block tests one bit of a 16- or 32-bit operand, copies it to a carry output and, depending on a 2-bit operation code, leaves it alone, sets it, clears it or inverts it. It has no variable-index bit selector. A single right-only rotator first moves the chosen bit down to position 0. A one-bit editor then works on bit 0. The same rotator then rotates the word by the complementary amount, so the bits return to their original order.

For operands held in memory, the bit index is a signed number that may point outside the addressed word. The unit splits such an index into two parts: a position inside the word and a signed byte displacement, aligned to the operand size, which the caller adds to its address. In register mode the index simply wraps inside the word and the displacement is zero.

A controller with five states sequences the work. IDLE waits for `start_i`. SEEK rotates right by the position. EDIT captures the carry and changes bit 0. RESTORE rotates right by width minus position. DONE raises `done_o` for one cycle. The transitions are IDLE→SEEK on start, SEEK→EDIT, EDIT→RESTORE and RESTORE→DONE unconditionally, then DONE→SEEK on start or DONE→IDLE otherwise.

Top module: `bit_test_unit`

## Requirements
- R1: `cf_o` equals the original value of the selected bit for all four operations.
- R2: `op_i` encoding: 0 passes the bit unchanged, 1 forces it to 1, 2 forces it to 0 and 3 inverts it. Every other bit of the result equals the operand.
- R3: With `op_i`=0, `result_o` equals the operand.
- R4: With `mem_i`=0, the bit position is the index modulo the width (index bits [4:0] when `wide_i`=1, bits [3:0] when `wide_i`=0) and `boff_o` is 0.
- R5: With `mem_i`=1, the index is two's complement and the position is taken from its low bits as in R4. `boff_o` is the index arithmetically shifted right by 3 and then aligned down to the operand size (multiple of 4 bytes when `wide_i`=1, of 2 when `wide_i`=0). For example, index 35 on a dword gives bit 3 at offset +4, and index -1 gives bit 31 at offset -4.
- R6: With `wide_i`=0, only `opnd_i[15:0]` is used and `result_o[31:16]` is 0.
- R7: A start accepted at clock edge k gives `done_o`=1 for exactly the cycle after edge k+3. A start is accepted in IDLE and also in the DONE cycle itself. `result_o`, `cf_o` and `boff_o` hold their values until the next accepted start.
- R8: `start_i` raised during SEEK, EDIT or RESTORE is ignored. It neither alters the operation in flight nor causes a second completion.
- R9: After reset, `done_o`, `result_o`, `cf_o` and `boff_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled in IDLE or DONE |
| op_i | input | 2 | Operation: 0 test, 1 set, 2 clear, 3 invert |
| mem_i | input | 1 | 1 = signed memory index with byte displacement |
| wide_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| opnd_i | input | 32 | Operand |
| idx_i | input | 32 | Bit index |
| result_o | output | 32 | Modified operand |
| cf_o | output | 1 | Original value of the selected bit |
| boff_o | output | 32 | Signed byte displacement |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: one operation completing, and the next operation being accepted. The bench provokes this by raising `start_i` exactly in the cycle where `done_o` is high. In that cycle it judges the first operation's result, carry and displacement. It then checks that the second operation completes four edges later with its own independent values. It also raises `start_i` in the middle of an operation and confirms that the in-flight result is untouched and that only one completion appears.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        OP_TEST = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_FLIP = 2'd3
    } bt_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEEK,
        S_EDIT,
        S_RESTORE,
        S_DONE
    } bt_state_e;
endpackage

// File: rtl/bt_rotr.sv
module bt_rotr #(
    parameter int DW = 32,
    localparam int AW = $clog2(DW),
    localparam int HW = DW / 2
) (
    input  logic [DW-1:0] din,
    input  logic          wide,
    input  logic [AW-1:0] amt,
    output logic [DW-1:0] dout
);
    logic [AW-1:0]   amt_eff;
    logic [2*DW-1:0] src;
    logic [2*DW-1:0] coarse;
    logic [DW-1:0]   fine;

    always_comb begin
        amt_eff = wide ? amt : {1'b0, amt[AW-2:0]};
        src     = wide ? {din, din} : {{DW{1'b0}}, din[HW-1:0], din[HW-1:0]};
        coarse  = src >> {amt_eff[AW-1:2], 2'b00};
        fine    = DW'(coarse >> amt_eff[1:0]);
        dout    = wide ? fine : {{HW{1'b0}}, fine[HW-1:0]};
    end
endmodule

// File: rtl/bt_index.sv
module bt_index #(
    parameter int DW = 32,
    parameter int IW = 32,
    localparam int AW = $clog2(DW)
) (
    input  logic [IW-1:0] idx,
    input  logic          wide,
    input  logic          mem,
    output logic [AW-1:0] pos,
    output logic [IW-1:0] boff
);
    logic signed [IW-1:0] bytes;
    logic        [IW-1:0] align_mask;

    always_comb begin
        pos        = wide ? idx[AW-1:0] : {1'b0, idx[AW-2:0]};
        bytes      = $signed(idx) >>> 3;
        align_mask = wide ? IW'(DW / 8 - 1) : IW'(DW / 16 - 1);
        boff       = mem ? (IW'(bytes) & ~align_mask) : '0;
    end
endmodule

// File: rtl/bt_edit.sv
module bt_edit
    import bt_pkg::*;
(
    input  logic   bit_in,
    input  bt_op_e op,
    output logic   bit_out
);
    always_comb begin
        unique case (op)
            OP_TEST: bit_out = bit_in;
            OP_SET:  bit_out = bit_in | 1'b1;
            OP_CLR:  bit_out = bit_in & 1'b0;
            OP_FLIP: bit_out = bit_in ^ 1'b1;
            default: bit_out = bit_in;
        endcase
    end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
    import bt_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 32,
    localparam int AW = $clog2(DW),
    localparam int HW = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic          mem_i,
    input  logic          wide_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [IW-1:0] idx_i,
    output logic [DW-1:0] result_o,
    output logic          cf_o,
    output logic [IW-1:0] boff_o,
    output logic          done_o
);
    bt_state_e     state_q, state_d;
    logic [DW-1:0] work_q;
    logic [AW-1:0] pos_q;
    bt_op_e        op_q;
    logic          wide_q;
    logic          mem_q;
    logic          cf_q;
    logic [IW-1:0] boff_pend_q;
    logic [IW-1:0] boff_q;

    logic          accept;
    logic [AW-1:0] idx_pos;
    logic [IW-1:0] idx_boff;
    logic [AW-1:0] rot_amt;
    logic [DW-1:0] rot_out;
    logic          edit_bit;

    bt_index #(.DW(DW), .IW(IW)) u_index (
        .idx  (idx_i),
        .wide (wide_i),
        .mem  (mem_i),
        .pos  (idx_pos),
        .boff (idx_boff)
    );

    bt_rotr #(.DW(DW)) u_rotr (
        .din  (work_q),
        .wide (wide_q),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    bt_edit u_edit (
        .bit_in  (work_q[0]),
        .op      (op_q),
        .bit_out (edit_bit)
    );

    assign accept  = start_i && (state_q == S_IDLE || state_q == S_DONE);
    assign rot_amt = (state_q == S_SEEK) ? pos_q : AW'(AW'(0) - pos_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_SEEK;
            S_SEEK:    state_d = S_EDIT;
            S_EDIT:    state_d = S_RESTORE;
            S_RESTORE: state_d = S_DONE;
            S_DONE:    state_d = start_i ? S_SEEK : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q      <= '0;
            pos_q       <= '0;
            op_q        <= OP_TEST;
            wide_q      <= 1'b1;
            mem_q       <= 1'b0;
            cf_q        <= 1'b0;
            boff_pend_q <= '0;
            boff_q      <= '0;
        end else begin
            if (accept) begin
                work_q      <= wide_i ? opnd_i : {{HW{1'b0}}, opnd_i[HW-1:0]};
                pos_q       <= idx_pos;
                op_q        <= bt_op_e'(op_i);
                wide_q      <= wide_i;
                mem_q       <= mem_i;
                boff_pend_q <= idx_boff;
            end else begin
                unique case (state_q)
                    S_SEEK:    work_q <= rot_out;
                    S_EDIT: begin
                        cf_q   <= work_q[0];
                        work_q <= {work_q[DW-1:1], edit_bit};
                    end
                    S_RESTORE: begin
                        work_q <= rot_out;
                        boff_q <= boff_pend_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        done_o   = (state_q == S_DONE);
        result_o = work_q;
        cf_o     = cf_q;
        boff_o   = boff_q;
    end

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##4 done_o);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    busy_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEEK) |=> (state_q == S_EDIT));

    // R1
    carry_orig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cf_o == $past(work_q[pos_q], 3)));

    // R2
    other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (((result_o ^ $past(work_q, 3)) & ~(DW'(1) << pos_q)) == '0));

    // R3
    test_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_TEST) |-> (result_o == $past(work_q, 3)));

    // R4
    reg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mem_q) |-> (boff_o == '0));
endmodule

// File: tb/bit_test_unit_bench.sv
module bit_test_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        mem_i = 1'b0;
    logic        wide_i = 1'b1;
    logic [31:0] opnd_i = '0;
    logic [31:0] idx_i = '0;
    logic [31:0] result_o;
    logic        cf_o;
    logic [31:0] boff_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bit_test_unit u_bit_test_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .mem_i(mem_i), .wide_i(wide_i), .opnd_i(opnd_i), .idx_i(idx_i),
        .result_o(result_o), .cf_o(cf_o), .boff_o(boff_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] op, input logic mem, input logic wide,
                                  input logic [31:0] opnd, input logic [31:0] idx,
                                  output logic [31:0] res, output logic cf, output logic [31:0] boff);
        int w, p, q;
        logic [31:0] src;
        w   = wide ? 32 : 16;
        p   = int'(idx % w);
        src = wide ? opnd : {16'h0, opnd[15:0]};
        cf  = src[p];
        res = src;
        case (op)
            2'd1: res[p] = 1'b1;
            2'd2: res[p] = 1'b0;
            2'd3: res[p] = ~src[p];
            default: ;
        endcase
        q    = $signed(idx) >>> (wide ? 5 : 4);
        boff = mem ? 32'(q * (w / 8)) : 32'h0;
    endfunction

    task automatic kick(input logic [1:0] op, input logic mem, input logic wide,
                        input logic [31:0] opnd, input logic [31:0] idx);
        op_i = op; mem_i = mem; wide_i = wide; opnd_i = opnd; idx_i = idx;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic judge(input string rq, input logic [1:0] op, input logic mem, input logic wide,
                         input logic [31:0] opnd, input logic [31:0] idx);
        logic [31:0] er, eb;
        logic ec;
        model(op, mem, wide, opnd, idx, er, ec, eb);
        chk(done_o === 1'b1, {rq, " R7 done"}, 32'(done_o), 32'h1);
        chk(result_o === er, {rq, " result"}, result_o, er);
        chk(cf_o === ec, {rq, " R1 carry"}, 32'(cf_o), 32'(ec));
        chk(boff_o === eb, {rq, " offset"}, boff_o, eb);
    endtask

    task automatic run_op(input string rq, input logic [1:0] op, input logic mem, input logic wide,
                          input logic [31:0] opnd, input logic [31:0] idx);
        kick(op, mem, wide, opnd, idx);
        @(negedge clk);
        @(negedge clk);
        chk(done_o === 1'b0, {rq, " R7 early done"}, 32'(done_o), 32'h0);
        @(negedge clk);
        judge(rq, op, mem, wide, opnd, idx);
        @(negedge clk);
        chk(done_o === 1'b0, {rq, " R7 pulse width"}, 32'(done_o), 32'h0);
    endtask

    task automatic t_reset;
        chk(done_o === 1'b0, "R9 done", 32'(done_o), 32'h0);
        chk(result_o === 32'h0, "R9 result", result_o, 32'h0);
        chk(cf_o === 1'b0, "R9 carry", 32'(cf_o), 32'h0);
        chk(boff_o === 32'h0, "R9 offset", boff_o, 32'h0);
    endtask

    task automatic t_ops;
        run_op("R3 test bit7", 2'd0, 1'b0, 1'b1, 32'hA5C3_0F98, 32'd7);
        run_op("R3 test bit0", 2'd0, 1'b0, 1'b1, 32'h0000_0001, 32'd0);
        run_op("R2 set bit31", 2'd1, 1'b0, 1'b1, 32'h1234_5678, 32'd31);
        run_op("R2 set already", 2'd1, 1'b0, 1'b1, 32'h1234_5678, 32'd3);
        run_op("R2 clr bit0", 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd0);
        run_op("R2 clr bit13", 2'd2, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'd13);
        run_op("R2 flip bit31", 2'd3, 1'b0, 1'b1, 32'h8000_0001, 32'd31);
        run_op("R2 flip bit20", 2'd3, 1'b0, 1'b1, 32'h0F0F_0F0F, 32'd20);
    endtask

    task automatic t_register_wrap;
        run_op("R4 dword idx35", 2'd3, 1'b0, 1'b1, 32'h0000_00F0, 32'd35);
        run_op("R4 word idx21", 2'd1, 1'b0, 1'b0, 32'h0000_1234, 32'd21);
        run_op("R4 neg idx", 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_memory;
        run_op("R5 idx35", 2'd1, 1'b1, 1'b1, 32'h0000_0000, 32'd35);
        run_op("R5 idx-1", 2'd0, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R5 word idx-17", 2'd3, 1'b1, 1'b0, 32'h0000_8001, 32'hFFFF_FFEF);
        run_op("R5 idx100", 2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd100);
        run_op("R5 word idx40", 2'd0, 1'b1, 1'b0, 32'h0000_0100, 32'd40);
    endtask

    task automatic t_narrow;
        run_op("R6 word upper", 2'd0, 1'b0, 1'b0, 32'hFFFF_00FF, 32'd4);
        run_op("R6 word flip15", 2'd3, 1'b0, 1'b0, 32'hABCD_7FFF, 32'd15);
    endtask

    task automatic t_back_to_back;
        kick(2'd1, 1'b0, 1'b1, 32'h0000_0000, 32'd9);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        judge("R7 overlap first", 2'd1, 1'b0, 1'b1, 32'h0000_0000, 32'd9);
        kick(2'd3, 1'b1, 1'b1, 32'h5555_5555, 32'd66);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        judge("R7 overlap second", 2'd3, 1'b1, 1'b1, 32'h5555_5555, 32'd66);
        @(negedge clk);
    endtask

    task automatic t_busy_start;
        logic [31:0] er, eb;
        logic ec;
        kick(2'd1, 1'b0, 1'b1, 32'h0000_0010, 32'd2);
        op_i = 2'd2; opnd_i = 32'hFFFF_FFFF; idx_i = 32'd30; mem_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        judge("R8 busy start", 2'd1, 1'b0, 1'b1, 32'h0000_0010, 32'd2);
        model(2'd1, 1'b0, 1'b1, 32'h0000_0010, 32'd2, er, ec, eb);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(done_o === 1'b0, "R8 no second done", 32'(done_o), 32'h0);
        end
        chk(result_o === er, "R8 result held", result_o, er);
        chk(boff_o === eb, "R7 offset held", boff_o, eb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ops();
        t_register_wrap();
        t_memory();
        t_narrow();
        t_back_to_back();
        t_busy_start();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule